// File: doc/BRIEF.md
# Periodic Interrupt Divider

This block turns a 32768 Hz tick enable into a programmable periodic event. A free-running 15-bit tick counter advances once per tick. A 4-bit rate code picks a power-of-two period, and each time the counter reaches a whole multiple of that period the block emits a one-cycle event. The interrupt-flag logic next to it takes that event and sets its periodic flag bits.

The rate code is captured into an internal register only when the rate-register write strobe is high. The periodic enable is a live level input. Code 0 switches the events off. Codes 1 and 2 stand in for the two slow rates 8 and 9. Every other code `c` gives a period of 2^(c-1) ticks, so code 3 gives 4 ticks (8192 Hz) and code 15 gives 16384 ticks (2 Hz).

The counter is never reloaded. For this reason an event always lands on a boundary of the free-running count, and never at a point measured from the moment of a register write.

Top module: `periodic_irq_divider`

## Requirements
- R1: A synchronous active-high reset clears the tick counter to 0, sets the captured rate code to 0 (events off) and drives `evt_o` low.
- R2: While the captured rate code is 0, `evt_o` never goes high.
- R3: While `per_en` is low, `evt_o` never goes high. The tick counter keeps counting, so when `per_en` returns, events stay aligned to the count.
- R4: For a captured code c in 3..15, the period is 2^(c-1) ticks. For example, code 3 gives 4 ticks and code 15 gives 16384 ticks.
- R5: Code 1 behaves as code 8 (128 ticks) and code 2 behaves as code 9 (256 ticks).
- R6: An event is produced for the tick that brings the count since reset to a whole multiple of the period. `evt_o` goes high in the cycle after that tick's clock edge. The event is never timed from a rate write.
- R7: `rate_code` is captured only in a cycle with `rate_wr` high. Changes to `rate_code` at any other time have no effect.
- R8: Each event is exactly one clock cycle wide.
- R9: After a rate change, the next event comes at the next multiple of the new period on the running count. No extra pulse and no shortened period is produced.
- R10: In a cycle with `tick_en` low, the counter holds its value and no event is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle enable for each 32768 Hz tick |
| rate_code | input | 4 | Rate select code, captured on `rate_wr` |
| rate_wr | input | 1 | Rate-register write strobe |
| per_en | input | 1 | Periodic interrupt enable level |
| evt_o | output | 1 | One-cycle periodic event |

## Verification
The hardest situation to reach is a rate change made part-way through a period, because the next event then depends on the running count and not on the write. The stimulus reaches it with a fixed number of ticks after reset under one code. It then writes a new code while holding `tick_en` low, so the count is known exactly, and single-steps ticks to see which tick produces the first event. The slowest code needs more than sixteen thousand ticks, so one vector runs long enough to see a single 2 Hz boundary. A cycle-accurate reference counter in the bench flags any event that is early, late or too wide.

// File: rtl/pi_div_pkg.sv
`timescale 1ns/1ps
package pi_div_pkg;

   // default geometry of the divider
   localparam int PI_CNT_W_DEF      = 15;
   localparam int PI_CODE_W_DEF     = 4;
   localparam int PI_REMAP_MAX_DEF  = 2;
   localparam int PI_REMAP_ADD_DEF  = 7;

   // map a raw rate code onto the code that sets the divide ratio
   function automatic int pi_eff_code(input int code, input int rmax, input int radd);
      if (code != 0 && code <= rmax) return code + radd;
      return code;
   endfunction

   // largest effective code reachable with a given code width
   function automatic int pi_max_eff(input int code_w, input int rmax, input int radd);
      int top_code;
      top_code = (1 << code_w) - 1;
      if (rmax + radd > top_code) return rmax + radd;
      return top_code;
   endfunction

endpackage

// File: rtl/pi_tick_counter.sv
`timescale 1ns/1ps
module pi_tick_counter #(
   parameter int CNT_W = pi_div_pkg::PI_CNT_W_DEF
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick_en,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_nxt
);

   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   assign cnt_nxt = cnt_q + ONE;

   always_ff @(posedge clk) begin
      if (rst)          cnt_q <= '0;
      else if (tick_en) cnt_q <= cnt_nxt;
   end

endmodule

// File: rtl/pi_rate_decode.sv
`timescale 1ns/1ps
module pi_rate_decode #(
   parameter int CODE_W    = pi_div_pkg::PI_CODE_W_DEF,
   parameter int CNT_W     = pi_div_pkg::PI_CNT_W_DEF,
   parameter int REMAP_MAX = pi_div_pkg::PI_REMAP_MAX_DEF,
   parameter int REMAP_ADD = pi_div_pkg::PI_REMAP_ADD_DEF
) (
   input  logic [CODE_W-1:0] code_i,
   output logic              active_o,
   output logic [CNT_W-1:0]  mask_o
);

   int eff_c;
   int shift_c;

   assign active_o = (code_i != '0);

   always_comb begin
      eff_c   = pi_div_pkg::pi_eff_code(int'(code_i), REMAP_MAX, REMAP_ADD);
      shift_c = (eff_c == 0) ? 0 : eff_c - 1;
   end

   // bit b of the mask is set when it lies below log2(period)
   for (genvar b = 0; b < CNT_W; b++) begin : g_mask
      assign mask_o[b] = active_o && (shift_c > b);
   end

endmodule

// File: rtl/pi_boundary.sv
`timescale 1ns/1ps
module pi_boundary #(
   parameter int CNT_W   = pi_div_pkg::PI_CNT_W_DEF,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick_en,
   input  logic             enable_i,
   input  logic [CNT_W-1:0] mask_i,
   input  logic [CNT_W-1:0] cnt_nxt_i,
   output logic             evt_o
);

   logic hit;

   // the tick that rolls every masked bit to zero is a period boundary
   assign hit = tick_en && enable_i && ((cnt_nxt_i & mask_i) == '0);

   if (OUT_REG) begin : g_reg
      logic evt_q;
      always_ff @(posedge clk) begin
         if (rst) evt_q <= 1'b0;
         else     evt_q <= hit;
      end
      assign evt_o = evt_q;
   end else begin : g_comb
      assign evt_o = hit;
   end

endmodule

// File: rtl/periodic_irq_divider.sv
`timescale 1ns/1ps
module periodic_irq_divider #(
   parameter int CNT_W     = pi_div_pkg::PI_CNT_W_DEF,
   parameter int CODE_W    = pi_div_pkg::PI_CODE_W_DEF,
   parameter int REMAP_MAX = pi_div_pkg::PI_REMAP_MAX_DEF,
   parameter int REMAP_ADD = pi_div_pkg::PI_REMAP_ADD_DEF,
   parameter bit OUT_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick_en,
   input  logic [CODE_W-1:0] rate_code,
   input  logic              rate_wr,
   input  logic              per_en,
   output logic              evt_o
);

   localparam int MAX_SHIFT = pi_div_pkg::pi_max_eff(CODE_W, REMAP_MAX, REMAP_ADD) - 1;

   // elaboration-time parameter checks
   if (MAX_SHIFT > CNT_W) begin : g_bad_cnt
      $error("periodic_irq_divider: CNT_W too small for slowest rate");
   end
   if (REMAP_MAX < 1 || REMAP_MAX >= (1 << CODE_W)) begin : g_bad_remap
      $error("periodic_irq_divider: REMAP_MAX out of range");
   end
   if (CODE_W < 2) begin : g_bad_code
      $error("periodic_irq_divider: CODE_W must be at least 2");
   end

   logic [CODE_W-1:0] code_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  cnt_nxt;
   logic [CNT_W-1:0]  mask;
   logic              active;

   always_ff @(posedge clk) begin
      if (rst)          code_q <= '0;
      else if (rate_wr) code_q <= rate_code;
   end

   pi_tick_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .tick_en (tick_en),
      .cnt_q   (cnt_q),
      .cnt_nxt (cnt_nxt)
   );

   pi_rate_decode #(
      .CODE_W    (CODE_W),
      .CNT_W     (CNT_W),
      .REMAP_MAX (REMAP_MAX),
      .REMAP_ADD (REMAP_ADD)
   ) u_dec (
      .code_i   (code_q),
      .active_o (active),
      .mask_o   (mask)
   );

   pi_boundary #(.CNT_W(CNT_W), .OUT_REG(OUT_REG)) u_bnd (
      .clk       (clk),
      .rst       (rst),
      .tick_en   (tick_en),
      .enable_i  (active && per_en),
      .mask_i    (mask),
      .cnt_nxt_i (cnt_nxt),
      .evt_o     (evt_o)
   );

endmodule

// File: rtl/pi_div_chk.sv
`timescale 1ns/1ps
module pi_div_chk #(
   parameter int CNT_W     = 15,
   parameter int CODE_W    = 4,
   parameter int REMAP_MAX = 2,
   parameter bit OUT_REG   = 1'b1
) (
   input logic              clk,
   input logic              rst,
   input logic              tick_en,
   input logic              per_en,
   input logic [CODE_W-1:0] code_q,
   input logic [CNT_W-1:0]  cnt_q,
   input logic              evt_o
);

   // shortest period is 2^REMAP_MAX ticks
   localparam logic [CNT_W-1:0] LOW_MASK = CNT_W'((1 << REMAP_MAX) - 1);
   localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

   // R8
   evt_single_chk: assert property (@(posedge clk) disable iff (rst)
      evt_o |=> !evt_o);

   // R10
   cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !tick_en |=> $stable(cnt_q));

   if (OUT_REG) begin : g_reg_chk
      // R6
      evt_aligned_chk: assert property (@(posedge clk) disable iff (rst)
         evt_o |-> ((cnt_q & LOW_MASK) == '0));
      // R3
      evt_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
         evt_o |-> $past(per_en));
      // R2
      evt_code_zero_chk: assert property (@(posedge clk) disable iff (rst)
         evt_o |-> ($past(code_q) != '0));
   end else begin : g_comb_chk
      // R6
      evt_aligned_chk: assert property (@(posedge clk) disable iff (rst)
         evt_o |-> (tick_en && (((cnt_q + ONE) & LOW_MASK) == '0)));
      // R3
      evt_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
         evt_o |-> per_en);
      // R2
      evt_code_zero_chk: assert property (@(posedge clk) disable iff (rst)
         evt_o |-> (code_q != '0));
   end

endmodule

bind periodic_irq_divider pi_div_chk #(
   .CNT_W     (CNT_W),
   .CODE_W    (CODE_W),
   .REMAP_MAX (REMAP_MAX),
   .OUT_REG   (OUT_REG)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .tick_en (tick_en),
   .per_en  (per_en),
   .code_q  (code_q),
   .cnt_q   (cnt_q),
   .evt_o   (evt_o)
);

// File: tb/periodic_irq_divider_tb.sv
`timescale 1ns/1ps
module periodic_irq_divider_tb;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       tick_en = 1'b0;
   logic [3:0] rate_code = 4'd0;
   logic       rate_wr = 1'b0;
   logic       per_en = 1'b0;
   logic       evt_o;

   always #4 clk = ~clk;   // 125 MHz

   periodic_irq_divider u_dut (
      .clk       (clk),
      .rst       (rst),
      .tick_en   (tick_en),
      .rate_code (rate_code),
      .rate_wr   (rate_wr),
      .per_en    (per_en),
      .evt_o     (evt_o)
   );

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   // reference model built from the requirements
   logic [14:0] cnt_m  = '0;
   logic [14:0] nx_m;
   logic [3:0]  code_m = '0;
   logic        exp_m  = 1'b0;
   int mism   = 0;
   int ev_cnt = 0;
   int dbl    = 0;
   bit prev_evt = 1'b0;

   function automatic int per_of(input logic [3:0] c);
      int e;
      if (c == 4'd0) return 1;
      e = (c == 4'd1) ? 8 : (c == 4'd2) ? 9 : int'(c);
      return 1 << (e - 1);
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         cnt_m  <= '0;
         code_m <= '0;
         exp_m  <= 1'b0;
      end else begin
         nx_m = cnt_m + 15'd1;
         exp_m <= tick_en && per_en && (code_m != 4'd0) &&
                  ((int'(nx_m) % per_of(code_m)) == 0);
         if (rate_wr) code_m <= rate_code;
         if (tick_en) cnt_m <= nx_m;
      end
   end

   // compares the values held before this edge
   always @(posedge clk) begin
      if (!rst) begin
         if (evt_o !== exp_m) mism++;
         if (evt_o === 1'b1) begin
            ev_cnt++;
            if (prev_evt) dbl++;
         end
         prev_evt = (evt_o === 1'b1);
      end else begin
         prev_evt = 1'b0;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1; tick_en = 1'b0; rate_wr = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic wr_code(input logic [3:0] c);
      rate_code = c; rate_wr = 1'b1; tick_en = 1'b0;
      @(negedge clk);
      rate_wr = 1'b0;
   endtask

   task automatic run(input int n, input int gap);
      for (int i = 0; i < n; i++) begin
         tick_en = 1'b1;
         @(negedge clk);
         for (int g = 0; g < gap; g++) begin
            tick_en = 1'b0;
            @(negedge clk);
         end
      end
      tick_en = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   typedef struct packed {
      logic [3:0]  code;
      logic [15:0] ticks;
      logic [7:0]  gap;
      logic [15:0] exp_ev;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{4'd3,  16'd40,    8'd0, 16'd10},   // R4 period 4
      '{4'd4,  16'd40,    8'd0, 16'd5},    // R4 period 8
      '{4'd6,  16'd100,   8'd2, 16'd3},    // R10 gaps, period 32
      '{4'd1,  16'd300,   8'd0, 16'd2},    // R5 period 128
      '{4'd2,  16'd600,   8'd0, 16'd2},    // R5 period 256
      '{4'd0,  16'd100,   8'd0, 16'd0},    // R2 off
      '{4'd15, 16'd20000, 8'd0, 16'd1},    // R4 period 16384
      '{4'd5,  16'd64,    8'd1, 16'd4}     // R10 gaps, period 16
   };

   initial begin
      int e0, m0, d0;
      @(negedge clk);
      do_reset();
      per_en = 1'b1;
      chk(evt_o === 1'b0, "R1 reset evt", int'(evt_o), 0);

      // table of vectors, one loop
      for (int v = 0; v < 8; v++) begin
         do_reset();
         per_en = 1'b1;
         wr_code(VECS[v].code);
         e0 = ev_cnt; m0 = mism; d0 = dbl;
         run(int'(VECS[v].ticks), int'(VECS[v].gap));
         chk(ev_cnt - e0 == int'(VECS[v].exp_ev), "R4/R5/R2/R10 event count",
             ev_cnt - e0, int'(VECS[v].exp_ev));
         chk(mism == m0, "R6 cycle timing vs model", mism - m0, 0);
         chk(dbl == d0, "R8 single-cycle event", dbl - d0, 0);
      end

      // R1: reset clears the counter and the captured code
      do_reset(); per_en = 1'b1; wr_code(4'd3);
      run(2, 0);
      do_reset();
      e0 = ev_cnt; run(8, 0);
      chk(ev_cnt == e0, "R1 code cleared by reset", ev_cnt - e0, 0);
      wr_code(4'd3);
      do_reset(); wr_code(4'd3);
      e0 = ev_cnt; run(3, 0);
      chk(ev_cnt == e0, "R1 counter cleared by reset", ev_cnt - e0, 0);

      // R7: code changes without strobe are ignored
      do_reset(); per_en = 1'b1; wr_code(4'd3);
      rate_code = 4'd15;
      e0 = ev_cnt; run(40, 0);
      chk(ev_cnt - e0 == 10, "R7 unstrobed code ignored", ev_cnt - e0, 10);

      // R3: enable low blocks events, counter keeps running
      do_reset(); per_en = 1'b0; wr_code(4'd3);
      e0 = ev_cnt; run(42, 0);
      chk(ev_cnt == e0, "R3 disabled no events", ev_cnt - e0, 0);
      per_en = 1'b1;
      e0 = ev_cnt; run(2, 0);
      chk(ev_cnt - e0 == 1, "R3 aligned after re-enable", ev_cnt - e0, 1);

      // R9/R6: rate change part-way through a period
      do_reset(); per_en = 1'b1; wr_code(4'd3);
      run(6, 0);
      wr_code(4'd4);
      e0 = ev_cnt; run(1, 0);
      chk(ev_cnt == e0, "R9 no event at count 7", ev_cnt - e0, 0);
      e0 = ev_cnt; run(1, 0);
      chk(ev_cnt - e0 == 1, "R9 event at count 8", ev_cnt - e0, 1);
      e0 = ev_cnt; run(8, 0);
      chk(ev_cnt - e0 == 1, "R9 next at count 16", ev_cnt - e0, 1);
      chk(mism == 0, "R6 overall timing vs model", mism, 0);
      chk(dbl == 0, "R8 overall single-cycle", dbl, 0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule